// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the digital half of a programmable feedback divider for a frequency synthesiser loop. It is clocked by the output of an external 16/17 dual-modulus prescaler. It drives that prescaler's modulus-select line so that the total division from the RF input to the block's cycle pulse equals a 17-bit ratio word. Each division cycle is made of M prescaler periods. The first A of those periods divide by 17 and the rest divide by 16, so one cycle spans 16*M + A input periods.

A ratio is written with a one-cycle write strobe. The write is checked for validity and held as pending. It becomes active only when the current division cycle ends, so retuning never produces a shortened or stretched cycle. After reset, or while no valid ratio has been written, the block idles: it drives no pulse and the modulus line stays low. A toggle output that changes state once per cycle gives a half-rate copy of the divider output for test observation.

Top module: `pswallow_div`

## Requirements
- R1: While reset is asserted and after its release, until a valid ratio is written, mod_sel, cyc_pulse and half_out are 0 and no division cycle completes.
- R2: The ratio word is split into a swallow count A = ratio_in[3:0] and a main count M = ratio_in[16:4]. One division cycle lasts exactly 16*M + A periods of the prescaler input.
- R3: Within each cycle, mod_sel is 1 (select divide-by-17) during the first A prescaler periods and 0 during the remaining M−A periods. When M equals A, every period divides by 17.
- R4: cyc_pulse is 1 during exactly one prescaler period per cycle, the last one. Both counters restart at the edge that ends it.
- R5: A written word is valid only if M ≥ 1 and M ≥ A. An invalid word, including all zeros, is ignored, and the active ratio keeps running unchanged.
- R6: A valid word written during a running cycle takes effect at the end of that cycle. The cycle in progress completes with the old ratio.
- R7: From the idle state, a valid word becomes active at the next prescaler clock edge after it is captured. The first complete cycle then ends 16*M + A input periods after that edge.
- R8: half_out toggles at the end of every division cycle and at no other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ratio_we | input | 1 | One-cycle write strobe for ratio_in |
| ratio_in | input | 17 | Ratio word: M in bits 16..4, A in bits 3..0 |
| mod_sel | output | 1 | Modulus select to prescaler: 1 = divide by 17, 0 = divide by 16 |
| cyc_pulse | output | 1 | High for the last prescaler period of each division cycle |
| half_out | output | 1 | Divider output divided by 2 |

## Verification
The testbench contains a behavioural 16/17 prescaler that reads mod_sel at the start of each period. It counts input cycles between cycle ends and counts 17-periods and pulse periods per cycle. Directed ratios cover the edges of the space: M=1 with A of 0 or 1, M equal to A at the largest swallow count, A=0 with a larger M, and the largest A with M just above it. These separate a wrong split of the word, a modulus pattern that is off by one period, and a wrong reload point. Random valid ratios follow, mixed with invalid words (A above M, and M of zero). Each ratio change is timed mid-cycle, which shows whether the old cycle completes before the new ratio applies. A separate write from the idle state checks the immediate start.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;
  localparam int unsigned PS_RATIO_W = 17;
  localparam int unsigned PS_SWALLOW_W = 4;

  // A ratio is usable when there is at least one main period and
  // enough main periods to host every swallowed (divide-by-17) period.
  function automatic logic ratio_valid(input int unsigned m, input int unsigned a);
    return (m != 0) && (m >= a);
  endfunction

  // Input periods in one division cycle, for a prescaler base of 2**sw_w.
  function automatic int unsigned cycle_len(input int unsigned m, input int unsigned a,
                                            input int unsigned sw_w);
    return (m << sw_w) + a;
  endfunction
endpackage

// File: rtl/fdiv_ratio_bank.sv
module fdiv_ratio_bank #(
  parameter int unsigned MAIN_W = 13,
  parameter int unsigned SW_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [MAIN_W-1:0] wr_m,
  input  logic [SW_W-1:0]   wr_a,
  input  logic              cyc_end,
  output logic [MAIN_W-1:0] act_m,
  output logic [SW_W-1:0]   act_a,
  output logic              hold
);
  import pswallow_pkg::*;

  logic              pend_vld;
  logic [MAIN_W-1:0] pend_m;
  logic [SW_W-1:0]   pend_a;
  logic              wr_ok;
  logic              apply;

  assign wr_ok = we && ratio_valid(32'(wr_m), 32'(wr_a));
  assign hold  = (act_m == '0);
  assign apply = pend_vld && (cyc_end || hold);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld <= 1'b0;
      pend_m   <= '0;
      pend_a   <= '0;
    end else if (wr_ok) begin
      pend_vld <= 1'b1;
      pend_m   <= wr_m;
      pend_a   <= wr_a;
    end else if (apply) begin
      pend_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_m <= '0;
      act_a <= '0;
    end else if (apply) begin
      act_m <= pend_m;
      act_a <= pend_a;
    end
  end

  // R6
  act_only_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cyc_end) && !$past(hold)) |-> ($stable(act_m) && $stable(act_a)));
  // R5
  act_ratio_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold || ({{(MAIN_W-SW_W){1'b0}}, act_a} <= act_m));
endmodule

// File: rtl/fdiv_swallow_ctr.sv
module fdiv_swallow_ctr #(
  parameter int unsigned MAIN_W = 13,
  parameter int unsigned SW_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MAIN_W-1:0] act_m,
  input  logic [SW_W-1:0]   act_a,
  input  logic              hold,
  output logic              mod_sel,
  output logic              cyc_end
);
  logic [MAIN_W-1:0] pidx;
  logic [MAIN_W-1:0] last_idx;
  logic [MAIN_W-1:0] a_ext;

  assign a_ext    = {{(MAIN_W-SW_W){1'b0}}, act_a};
  assign last_idx = act_m - MAIN_W'(1);
  assign cyc_end  = !hold && (pidx == last_idx);
  assign mod_sel  = !hold && (pidx < a_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pidx <= '0;
    else if (hold || cyc_end) pidx <= '0;
    else                     pidx <= pidx + MAIN_W'(1);
  end

  // R4
  reload_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |=> (pidx == '0));
  // R3
  idle_no_swallow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !mod_sel && !cyc_end);
  // R3
  swallow_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(mod_sel) && !$past(cyc_end) && !$past(hold) && !hold) |-> !mod_sel);
endmodule

// File: rtl/fdiv_half.sv
module fdiv_half (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_end,
  output logic half
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       half <= 1'b0;
    else if (cyc_end) half <= ~half;
  end

  // R8
  half_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cyc_end) |-> $stable(half));
  // R8
  half_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cyc_end) |-> (half != $past(half)));
endmodule

// File: rtl/pswallow_div.sv
module pswallow_div #(
  parameter int unsigned RATIO_W = pswallow_pkg::PS_RATIO_W,
  parameter int unsigned SW_W = pswallow_pkg::PS_SWALLOW_W
) (
  input  logic               pclk,
  input  logic               rst_n,
  input  logic               ratio_we,
  input  logic [RATIO_W-1:0] ratio_in,
  output logic               mod_sel,
  output logic               cyc_pulse,
  output logic               half_out
);
  localparam int unsigned MAIN_W = RATIO_W - SW_W;

  logic [MAIN_W-1:0] act_m;
  logic [SW_W-1:0]   act_a;
  logic              hold;
  logic              cyc_end;

  fdiv_ratio_bank #(.MAIN_W(MAIN_W), .SW_W(SW_W)) u_bank (
    .clk(pclk), .rst_n(rst_n), .we(ratio_we),
    .wr_m(ratio_in[RATIO_W-1:SW_W]), .wr_a(ratio_in[SW_W-1:0]),
    .cyc_end(cyc_end), .act_m(act_m), .act_a(act_a), .hold(hold)
  );

  fdiv_swallow_ctr #(.MAIN_W(MAIN_W), .SW_W(SW_W)) u_ctr (
    .clk(pclk), .rst_n(rst_n), .act_m(act_m), .act_a(act_a), .hold(hold),
    .mod_sel(mod_sel), .cyc_end(cyc_end)
  );

  fdiv_half u_half (
    .clk(pclk), .rst_n(rst_n), .cyc_end(cyc_end), .half(half_out)
  );

  assign cyc_pulse = cyc_end;

  // R1
  idle_silent_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    hold |-> !cyc_pulse && !mod_sel);
endmodule

// File: tb/test_pswallow_div.sv
module test_pswallow_div;
  localparam int RF_PERIOD = 10;

  logic        rf = 1'b0;
  logic        pclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ratio_we = 1'b0;
  logic [16:0] ratio_in = '0;
  logic        mod_sel, cyc_pulse, half_out;

  pswallow_div i_pswallow_div (
    .pclk(pclk), .rst_n(rst_n), .ratio_we(ratio_we), .ratio_in(ratio_in),
    .mod_sel(mod_sel), .cyc_pulse(cyc_pulse), .half_out(half_out)
  );

  always #(RF_PERIOD/2) rf = ~rf;

  int nchk = 0, nfail = 0;
  int rc = 0, plen = 16, rfcnt = 0, last_b = 0, nb = 0, intv = 0;
  int n17 = 0, nper = 0, npul = 0, s17 = 0, sper = 0, spul = 0;
  int hbad = 0;
  logic hlast = 1'b0;
  logic [16:0] cur_w = '0;
  bit done = 0;

  // behavioural 16/17 prescaler plus cycle measurement
  always @(posedge rf) begin
    rfcnt++;
    if (rc == plen - 1) begin
      rc = 0;
      if (rst_n && cyc_pulse) begin
        intv = rfcnt - last_b; last_b = rfcnt;
        s17 = n17; sper = nper; spul = npul;
        n17 = 0; nper = 0; npul = 0;
        if (nb > 0 && half_out == hlast) hbad++;
        hlast = half_out;
        nb++;
      end
      pclk = 1'b1;
    end else begin
      rc++;
      if (rc == 1) begin
        plen = mod_sel ? 17 : 16;
        nper++;
        if (mod_sel) n17++;
        if (cyc_pulse) npul++;
      end
      if (rc == 8) pclk = 1'b0;
    end
  end

  function automatic int exp_len(input logic [16:0] w);
    return 16 * int'(w[16:4]) + int'(w[3:0]);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [16:0] w);
    @(negedge pclk);
    ratio_in = w; ratio_we = 1'b1;
    @(negedge pclk);
    ratio_we = 1'b0;
  endtask

  // valid ratio written mid-cycle; old cycle must finish first (R6)
  task automatic run_ratio(input logic [16:0] w);
    int t0;
    int old_len;
    bit old_multi;
    old_len = exp_len(cur_w);
    old_multi = (cur_w[16:4] >= 2);
    t0 = nb;
    wait (nb > t0);
    t0 = nb;
    write_word(w);
    wait (nb >= t0 + 1);
    @(negedge rf);
    if (old_multi) check("R6 old cycle kept", intv, old_len);
    wait (nb >= t0 + 3);
    @(negedge rf);
    check("R2 cycle length", intv, exp_len(w));
    check("R3 periods by 17", s17, int'(w[3:0]));
    check("R3 total periods", sper, int'(w[16:4]));
    check("R4 pulse periods", spul, 1);
    cur_w = w;
  endtask

  task automatic try_invalid(input logic [16:0] w);
    int t0;
    t0 = nb;
    wait (nb > t0);
    t0 = nb;
    write_word(w);
    wait (nb >= t0 + 3);
    @(negedge rf);
    check("R5 invalid ignored", intv, exp_len(cur_w));
  endtask

  initial begin
    #(RF_PERIOD * 150000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL R2 watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int l0;
    logic [16:0] w;
    void'($urandom(32'd20240611));
    repeat (60) @(negedge rf);
    check("R1 mod_sel in reset", int'(mod_sel), 0);
    check("R1 cyc_pulse in reset", int'(cyc_pulse), 0);
    check("R1 half_out in reset", int'(half_out), 0);
    @(negedge rf); rst_n = 1'b1;
    repeat (300) @(negedge rf);
    check("R1 no cycle while idle", nb, 0);
    check("R1 mod_sel idle", int'(mod_sel), 0);
    check("R1 half_out idle", int'(half_out), 0);

    // R7: start from idle
    w = {13'd5, 4'd3};
    @(negedge pclk); @(negedge rf);
    l0 = rfcnt;
    ratio_in = w; ratio_we = 1'b1;
    @(negedge pclk); ratio_we = 1'b0;
    wait (nb >= 1);
    @(negedge rf);
    check("R7 start from idle", int'((last_b - l0) >= exp_len(w) && (last_b - l0) <= exp_len(w) + 34), 1);
    wait (nb >= 2);
    @(negedge rf);
    check("R2 first ratio length", intv, exp_len(w));
    check("R3 first ratio swallow", s17, 3);
    cur_w = w;

    run_ratio({13'd1, 4'd0});
    run_ratio({13'd1, 4'd1});
    run_ratio({13'd15, 4'd15});
    run_ratio({13'd20, 4'd0});
    run_ratio({13'd16, 4'd15});
    run_ratio({13'd100, 4'd7});

    try_invalid({13'd3, 4'd9});
    try_invalid(17'd0);
    try_invalid({13'd0, 4'd5});

    for (int k = 0; k < 8; k++) begin
      logic [12:0] m;
      logic [3:0] a;
      m = 13'(1 + ($urandom % 80));
      a = 4'($urandom % 16);
      if ({9'd0, a} > m) a = m[3:0];
      run_ratio({m, a});
    end

    check("R8 half toggles per cycle", hbad, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule